// File: doc/BRIEF.md
# Comma-Based Word Aligner for a 10-Bit Line Code

This block takes a recovered serial stream one bit per clock and finds where each 10-bit code group starts. It uses the comma: a seven-bit run that only some control characters carry, and that ordinary traffic never produces at any other bit position. The comma is either two zeros followed by five ones, or the inverse of that run. Once a comma is seen, the bit where it starts becomes the group boundary. From then on, every ten received bits are handed out as one aligned group, with a one-cycle valid strobe and a flag that marks groups opening with a comma.

The aligner starts in a hunting state. While hunting, each comma moves the boundary to its own position. The aligner locks once the same boundary has been confirmed by a set number of consecutive commas, three by default. While locked, the boundary is frozen and stray commas at other positions are ignored. Only an explicit relock request drops the lock and starts the hunt again. Decoding and lane deskew belong to the stages downstream.

Top module: `comma_aligner`

## Requirements
- R1: A comma is the seven-bit run 0011111 or 1100000, written earliest bit first. Either polarity is recognised, with its first bit at any position of the stream.
- R2: In `code_out`, bit 9 holds the earliest received bit of the group and bit 0 holds the latest.
- R3: After reset, `code_valid` and `locked` are low. After reset or a relock, `code_valid` stays low until a comma has been received.
- R4: While hunting, a received comma sets the boundary to the comma's first bit. The group that starts with it is emitted, and so is every following group of ten bits at that boundary.
- R5: `locked` rises in the same cycle as the output of the third consecutive comma found at the same boundary.
- R6: While hunting, a comma found at a different boundary restarts the count of confirming commas at one.
- R7: While locked, the boundary does not move. `code_valid` pulses exactly every ten cycles, and a comma at another bit position gives no group with `code_comma` set.
- R8: `locked` stays high until `relock` is sampled high. `locked` is low in the next cycle, and the old boundary is discarded.
- R9: `code_valid` is high for one cycle per group. It is seen one clock edge after the edge that samples the group's last bit.
- R10: `code_comma` is high exactly for emitted groups whose first seven bits form a comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial bit, one per cycle |
| relock | input | 1 | Drop the lock and hunt for a new boundary |
| code_out | output | 10 | Aligned code group, earliest bit in the MSB |
| code_valid | output | 1 | One-cycle strobe for a new group on `code_out` |
| code_comma | output | 1 | The group on `code_out` starts with a comma |
| locked | output | 1 | Boundary confirmed and frozen |

## Verification
The bench uses the default parameters: 10-bit groups, a 7-bit comma and a lock after three confirmations. With these values a junk prefix of 0 to 12 bits moves the character stream through every one of the ten boundary phases, and more than once. For each phase the bench predicts the value, comma flag, arrival cycle and lock flag of every group from the stream position alone. Single-bit slips placed before and after lock reach the count restart, the frozen boundary and the relock path.

// File: rtl/comma_align_pkg.sv
`timescale 1ns/1ps
package comma_align_pkg;

  typedef enum logic {ST_HUNT, ST_LOCK} align_state_e;

  // phase arithmetic modulo the group width
  function automatic int next_phase(int cur, int width);
    return (cur == width - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/comma_window.sv
`timescale 1ns/1ps
module comma_window #(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111,
  parameter int PH_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  output logic [CHAR_W-1:0] win,
  output logic [PH_W-1:0]   head_ph,
  output logic              full,
  output logic              comma_hit
);
  import comma_align_pkg::*;

  localparam int FILL_W = $clog2(CHAR_W + 1);

  logic [PH_W-1:0]    tail_ph;
  logic [FILL_W-1:0]  fill;
  logic [COMMA_W-1:0] head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win     <= '0;
      tail_ph <= PH_W'(CHAR_W - 1);
      fill    <= '0;
    end else begin
      win     <= {win[CHAR_W-2:0], rx_bit};
      tail_ph <= PH_W'(next_phase(int'(tail_ph), CHAR_W));
      if (fill != FILL_W'(CHAR_W)) fill <= fill + FILL_W'(1);
    end
  end

  // oldest bit in the window sits one phase after the newest one
  assign head_ph   = PH_W'(next_phase(int'(tail_ph), CHAR_W));
  assign full      = (fill == FILL_W'(CHAR_W));
  assign head      = win[CHAR_W-1 -: COMMA_W];
  assign comma_hit = full && ((head == COMMA_PAT) || (head == ~COMMA_PAT));

endmodule

// File: rtl/align_tracker.sv
`timescale 1ns/1ps
module align_tracker #(
  parameter int PH_W = 4,
  parameter int LOCK_HITS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            relock,
  input  logic            comma_hit,
  input  logic            full,
  input  logic [PH_W-1:0] head_ph,
  output logic            locked,
  output logic            bnd_known,
  output logic            take
);
  import comma_align_pkg::*;

  localparam int HIT_W = $clog2(LOCK_HITS + 1);

  align_state_e    st, st_n;
  logic [PH_W-1:0]  cand, cand_n;
  logic [HIT_W-1:0] hits, hits_n;
  logic             known, known_n;
  logic             same_ofs;

  assign same_ofs = known && (head_ph == cand);

  always_comb begin
    st_n    = st;
    cand_n  = cand;
    hits_n  = hits;
    known_n = known;
    if (relock) begin
      st_n    = ST_HUNT;
      hits_n  = '0;
      known_n = 1'b0;
    end else if (st == ST_HUNT && comma_hit) begin
      if (same_ofs) begin
        if (hits != HIT_W'(LOCK_HITS)) hits_n = hits + HIT_W'(1);
      end else begin
        cand_n = head_ph;
        hits_n = HIT_W'(1);
      end
      known_n = 1'b1;
      if (hits_n == HIT_W'(LOCK_HITS)) st_n = ST_LOCK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_HUNT;
      cand  <= '0;
      hits  <= '0;
      known <= 1'b0;
    end else begin
      st    <= st_n;
      cand  <= cand_n;
      hits  <= hits_n;
      known <= known_n;
    end
  end

  assign locked    = (st == ST_LOCK);
  assign bnd_known = known;
  assign take      = full && (locked ? (head_ph == cand) : (comma_hit || same_ofs));

endmodule

// File: rtl/group_out.sv
`timescale 1ns/1ps
module group_out #(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              comma_hit,
  input  logic [CHAR_W-1:0] win,
  output logic [CHAR_W-1:0] code_out,
  output logic              code_valid,
  output logic              code_comma
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_out   <= '0;
      code_valid <= 1'b0;
      code_comma <= 1'b0;
    end else begin
      code_valid <= take;
      code_comma <= take && comma_hit;
      if (take) code_out <= win;
    end
  end
endmodule

// File: rtl/comma_aligner.sv
`timescale 1ns/1ps
module comma_aligner #(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111,
  parameter int LOCK_HITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              relock,
  output logic [CHAR_W-1:0] code_out,
  output logic              code_valid,
  output logic              code_comma,
  output logic              locked
);
  localparam int PH_W = $clog2(CHAR_W);

  logic [CHAR_W-1:0] win;
  logic [PH_W-1:0]   head_ph;
  logic              full;
  logic              comma_hit;
  logic              bnd_known;
  logic              take;

  comma_window #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT), .PH_W(PH_W)
  ) win_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
    .win(win), .head_ph(head_ph), .full(full), .comma_hit(comma_hit)
  );

  align_tracker #(
    .PH_W(PH_W), .LOCK_HITS(LOCK_HITS)
  ) trk_i (
    .clk(clk), .rst_n(rst_n), .relock(relock), .comma_hit(comma_hit),
    .full(full), .head_ph(head_ph), .locked(locked),
    .bnd_known(bnd_known), .take(take)
  );

  group_out #(
    .CHAR_W(CHAR_W)
  ) out_i (
    .clk(clk), .rst_n(rst_n), .take(take), .comma_hit(comma_hit), .win(win),
    .code_out(code_out), .code_valid(code_valid), .code_comma(code_comma)
  );

endmodule

// File: rtl/comma_aligner_chk.sv
`timescale 1ns/1ps
module comma_aligner_chk #(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              relock,
  input logic [CHAR_W-1:0] code_out,
  input logic              code_valid,
  input logic              code_comma,
  input logic              locked,
  input logic              bnd_known,
  input logic              comma_hit
);
  logic [7:0] gap;
  logic       seen;
  logic       steady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      seen   <= 1'b0;
      steady <= 1'b0;
    end else if (code_valid) begin
      gap    <= '0;
      seen   <= 1'b1;
      steady <= locked;
    end else begin
      if (gap != 8'hFF) gap <= gap + 8'd1;
      steady <= steady && locked;
    end
  end

  assert_quiet_without_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd_known && !comma_hit) |=> !code_valid);

  assert_lock_on_comma_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (code_valid && code_comma));

  assert_locked_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && seen && steady && locked) |-> (gap == 8'(CHAR_W - 1)));

  assert_relock_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !locked);

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !relock) |=> locked);

  assert_comma_at_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    code_comma |-> (code_valid &&
      ((code_out[CHAR_W-1 -: COMMA_W] == COMMA_PAT) ||
       (code_out[CHAR_W-1 -: COMMA_W] == ~COMMA_PAT))));

endmodule

bind comma_aligner comma_aligner_chk #(
  .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .relock(relock), .code_out(code_out),
  .code_valid(code_valid), .code_comma(code_comma), .locked(locked),
  .bnd_known(bnd_known), .comma_hit(comma_hit)
);

// File: tb/comma_aligner_tb_top.sv
`timescale 1ns/1ps
module comma_aligner_tb_top;
  localparam logic [9:0] KM = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;
  localparam logic [9:0] DA = 10'b1010101010;
  localparam logic [9:0] DB = 10'b0101010101;
  localparam logic [9:0] DC = 10'b1001110100;

  logic clk = 1'b0;
  logic rst_n, rx_bit, relock;
  logic [9:0] code_out;
  logic code_valid, code_comma, locked;

  always #10 clk = ~clk;

  comma_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .relock(relock),
    .code_out(code_out), .code_valid(code_valid),
    .code_comma(code_comma), .locked(locked)
  );

  int total = 0, bad = 0, nb = 0, n_lg = 0;
  int lg_code[64], lg_com[64], lg_lock[64], lg_nb[64];
  logic [9:0] exp_ch[16];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic send_bit(input logic b, input logic rl);
    rx_bit = b;
    relock = rl;
    @(negedge clk);
    nb++;
    if (code_valid && n_lg < 64) begin
      lg_code[n_lg] = int'(code_out);
      lg_com[n_lg]  = int'(code_comma);
      lg_lock[n_lg] = int'(locked);
      lg_nb[n_lg]   = nb;
      n_lg++;
    end
  endtask

  task automatic send_char(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) send_bit(c[i], 1'b0);
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) send_bit((i % 2) == 0, 1'b0);
  endtask

  task automatic send_list(input int n);
    for (int k = 0; k < n; k++) send_char(exp_ch[k]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_bit = 1'b0; relock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nb = 0;
    n_lg = 0;
  endtask

  task automatic check_stream(input int base, input int n);
    int commas;
    commas = 0;
    check(n_lg >= n, "R4 group count", n_lg, n);
    for (int k = 0; k < n && k < n_lg; k++) begin
      bit isk;
      isk = (exp_ch[k] == KM) || (exp_ch[k] == KP);
      if (isk) commas++;
      check(lg_code[k] == int'(exp_ch[k]), "R2 R4 group value", lg_code[k], int'(exp_ch[k]));
      check(lg_com[k] == int'(isk), "R10 R1 comma flag", lg_com[k], int'(isk));
      check(lg_nb[k] == base + 10*k + 11, "R9 group timing", lg_nb[k], base + 10*k + 11);
      check(lg_lock[k] == int'(commas >= 3), "R5 lock flag", lg_lock[k], int'(commas >= 3));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int slip_nb, idx, lk_idx, base;
    logic [9:0] ck[5];
    int lk[5];

    // reset state
    do_reset();
    check(code_valid == 1'b0, "R3 valid after reset", int'(code_valid), 0);
    check(locked == 1'b0, "R3 locked after reset", int'(locked), 0);

    // every boundary phase, both comma polarities
    exp_ch[0] = KM; exp_ch[1] = DA; exp_ch[2] = KP; exp_ch[3] = DB;
    exp_ch[4] = KM; exp_ch[5] = DC; exp_ch[6] = KP; exp_ch[7] = DA;
    for (int p = 0; p < 13; p++) begin
      do_reset();
      send_junk(p);
      check(n_lg == 0, "R3 no group before comma", n_lg, 0);
      send_list(8);
      send_char(DA);
      check_stream(p, 8);
    end

    // R6: a slip while hunting restarts the confirmation count
    do_reset();
    send_junk(3);
    send_char(KM); send_char(DA); send_char(KP); send_char(DB);
    send_bit(1'b1, 1'b0);
    send_char(KM); send_char(DA); send_char(KP); send_char(DC);
    send_char(KM); send_char(DA); send_char(DA);
    ck[0] = KM; ck[1] = KP; ck[2] = KM; ck[3] = KP; ck[4] = KM;
    lk[0] = 0; lk[1] = 0; lk[2] = 0; lk[3] = 0; lk[4] = 1;
    idx = 0;
    for (int j = 0; j < n_lg; j++) begin
      if (lg_com[j] != 0) begin
        if (idx < 5) begin
          check(lg_code[j] == int'(ck[idx]), "R6 R4 comma group", lg_code[j], int'(ck[idx]));
          check(lg_lock[j] == lk[idx], "R6 lock after restart", lg_lock[j], lk[idx]);
        end
        idx++;
      end
    end
    check(idx == 5, "R6 comma group count", idx, 5);

    // R7: locked boundary ignores a slipped comma
    do_reset();
    send_junk(5);
    send_char(KM); send_char(DA); send_char(KP); send_char(DB);
    send_char(KM); send_char(DA);
    slip_nb = nb;
    send_bit(1'b1, 1'b0);
    send_char(KP); send_char(DA); send_char(KM); send_char(DC);
    send_char(KP); send_char(DA); send_char(DA);
    lk_idx = 4;
    check(n_lg >= 12, "R7 groups while locked", n_lg, 12);
    check(lg_lock[lk_idx] == 1, "R5 lock at third comma", lg_lock[lk_idx], 1);
    for (int j = lk_idx + 1; j < n_lg; j++) begin
      check(lg_lock[j] == 1, "R8 lock held", lg_lock[j], 1);
      check(lg_nb[j] - lg_nb[j-1] == 10, "R7 fixed spacing", lg_nb[j] - lg_nb[j-1], 10);
      if (lg_nb[j] > slip_nb + 1)
        check(lg_com[j] == 0, "R7 misplaced comma ignored", lg_com[j], 0);
    end

    // R8: relock clears the lock and the boundary
    send_bit(1'b1, 1'b1);
    check(locked == 1'b0, "R8 locked after relock", int'(locked), 0);
    send_bit(1'b0, 1'b0);
    n_lg = 0;
    send_junk(20);
    check(n_lg == 0, "R3 R8 silent after relock", n_lg, 0);
    check(locked == 1'b0, "R8 still hunting", int'(locked), 0);
    base = nb;
    send_list(8);
    send_char(DA);
    check_stream(base, 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule